// File: doc/BRIEF.md
# Bus Request Legality Screen

This block sits in front of a TileLink-UL style device on a 32-bit data bus with a 4-bit byte mask. It inspects every A-channel request against a stricter rule set than the base protocol. The rules cover the opcode, the size, which byte lanes the address and size make active, the shape of the mask, and an address-miss flag supplied by an external decoder. A request that passes every rule reaches the device port unchanged and without delay, and it obeys the device's ready.

A request that breaks any rule is accepted in the cycle it is presented and never reaches the device. It is parked in a one-entry error slot, and from the next cycle the slot drives an error response on the D channel. While the slot is occupied, no new request is accepted. The host-facing D channel shows the parked error in preference to any device response, and the device is held off until the host takes the error. Two parameters select device options: rejection of non-contiguous masks, and a register mode that allows only aligned full-word accesses.

Top module: `busreq_screen`

## Requirements
- R1: Only the opcodes 3'b000 (full write), 3'b001 (partial write) and 3'b100 (read) are legal. Any other value is an error.
- R2: The size field is 2 bits wide and the access is 2^size bytes. A size of 3 is an error.
- R3: Mask bit i covers byte lane i. The active lanes are: for size 0, the single lane addr[1:0]; for size 1, lanes {addr[1],0} and {addr[1],1}; for size 2, all four lanes. A mask bit set outside the active lanes is an error.
- R4: A full write (3'b000) whose mask does not set every active lane is an error.
- R5: With CONTIG_CHECK=1 (the default), the masks 0101, 1001, 1010, 1011 and 1101 are errors. With CONTIG_CHECK=0 they are judged by R3 and R4 alone.
- R6: A request presented with addr_miss_i=1 is an error.
- R7: With REG_ONLY=1, any request whose size is not 2 or whose addr[1:0] is not 00 is an error.
- R8: While the slot is empty, a legal request appears on the fw_* outputs in the same cycle, with every field unchanged, and a_ready_o equals fw_ready_i.
- R9: While the slot is empty, an illegal request sees a_ready_o=1 and fw_valid_o=0 in the same cycle. From the next cycle, d_valid_o=1 with d_error_o=1, d_data_o=0, the request's source and size echoed, and d_opcode_o=1 for a read or 0 for any other opcode. The response holds until d_ready_i=1.
- R10: While the slot is occupied, a_ready_o=0 and fw_valid_o=0. The slot empties at the clock edge where d_ready_i=1.
- R11: While the slot is occupied, the D outputs carry the error and dev_d_ready_o=0. While it is empty, the D outputs mirror the device response and dev_d_ready_o equals d_ready_i.
- R12: After reset the slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| a_valid_i | input | 1 | host request valid |
| a_ready_o | output | 1 | host request accepted |
| a_opcode_i | input | 3 | request opcode |
| a_size_i | input | SIZE_W | log2 of the access size in bytes |
| a_address_i | input | ADDR_W | request address |
| a_source_i | input | SRC_W | request identifier |
| a_mask_i | input | 4 | byte-lane mask |
| a_data_i | input | 32 | write data |
| addr_miss_i | input | 1 | external decoder: address does not exist |
| fw_valid_o | output | 1 | forwarded request valid |
| fw_ready_i | input | 1 | device accepts the forwarded request |
| fw_opcode_o | output | 3 | forwarded opcode |
| fw_size_o | output | SIZE_W | forwarded size |
| fw_address_o | output | ADDR_W | forwarded address |
| fw_source_o | output | SRC_W | forwarded identifier |
| fw_mask_o | output | 4 | forwarded mask |
| fw_data_o | output | 32 | forwarded write data |
| dev_d_valid_i | input | 1 | device response valid |
| dev_d_ready_o | output | 1 | device response taken |
| dev_d_opcode_i | input | 3 | device response opcode |
| dev_d_size_i | input | SIZE_W | device response size |
| dev_d_source_i | input | SRC_W | device response identifier |
| dev_d_data_i | input | 32 | device read data |
| dev_d_error_i | input | 1 | device response error |
| d_valid_o | output | 1 | host response valid |
| d_ready_i | input | 1 | host takes the response |
| d_opcode_o | output | 3 | host response opcode |
| d_size_o | output | SIZE_W | host response size |
| d_source_o | output | SRC_W | host response identifier |
| d_data_o | output | 32 | host response data |
| d_error_o | output | 1 | host response error |

## Verification
A device response can arrive in the same cycle that a parked error is waiting. Only one of the two can own the host D channel. The bench provokes this by parking an illegal request and then raising the device's response valid, with a distinct source ID, while d_ready_i is low. It judges the outcome at the ports: the error with its echoed source must win, and the device must see ready low. After the host takes the error, the device response must appear unchanged on the next cycle, together with a legal request that was held back during the wait.

// File: rtl/screen_pkg.sv
package screen_pkg;

  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned BUS_BITS  = BUS_BYTES * 8;

  typedef enum logic [2:0] {
    REQ_WR_FULL = 3'b000,
    REQ_WR_PART = 3'b001,
    REQ_RD      = 3'b100
  } req_op_e;

  typedef enum logic [2:0] {
    RSP_ACK      = 3'b000,
    RSP_ACK_DATA = 3'b001
  } rsp_op_e;

  // Byte lanes touched by an access, from the address low bits and size.
  function automatic logic [BUS_BYTES-1:0] lanes_of(input logic [1:0] lo,
                                                    input logic [1:0] sz);
    logic [BUS_BYTES-1:0] l;
    case (sz)
      2'd0:    l = 4'b0001 << lo;
      2'd1:    l = lo[1] ? 4'b1100 : 4'b0011;
      2'd2:    l = 4'b1111;
      default: l = 4'b0000;
    endcase
    return l;
  endfunction

  // True when the set bits form one unbroken run (empty counts as a run).
  function automatic logic is_run(input logic [BUS_BYTES-1:0] m);
    logic [BUS_BYTES-1:0] x;
    x = m;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (x != '0 && !x[0]) x = x >> 1;
    end
    return (x & BUS_BYTES'(x + 1'b1)) == '0;
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    return op == REQ_WR_FULL || op == REQ_WR_PART || op == REQ_RD;
  endfunction

endpackage

// File: rtl/screen_rules.sv
module screen_rules
  import screen_pkg::*;
#(
  parameter int unsigned SIZE_W       = 2,
  parameter bit          CONTIG_CHECK = 1'b1,
  parameter bit          REG_ONLY     = 1'b0
) (
  input  logic [2:0]           opcode_i,
  input  logic [SIZE_W-1:0]    size_i,
  input  logic [1:0]           addr_lo_i,
  input  logic [BUS_BYTES-1:0] mask_i,
  input  logic                 miss_i,
  output logic                 err_opcode_o,
  output logic                 err_size_o,
  output logic                 err_lane_o,
  output logic                 err_full_o,
  output logic                 err_contig_o,
  output logic                 err_region_o,
  output logic                 err_align_o,
  output logic                 bad_o
);
  localparam logic [SIZE_W-1:0] MAX_SIZE = SIZE_W'(2);

  logic [BUS_BYTES-1:0] active;
  logic                 size_ok;

  assign size_ok      = size_i <= MAX_SIZE;
  assign active       = lanes_of(addr_lo_i, size_i[1:0]);
  assign err_opcode_o = !op_known(opcode_i);
  assign err_size_o   = !size_ok;
  assign err_lane_o   = size_ok && ((mask_i & ~active) != '0);
  assign err_full_o   = (opcode_i == REQ_WR_FULL) && ((mask_i & active) != active);
  assign err_region_o = miss_i;

  generate
    if (CONTIG_CHECK) begin : g_contig
      assign err_contig_o = !is_run(mask_i);
    end else begin : g_no_contig
      assign err_contig_o = 1'b0;
    end
    if (REG_ONLY) begin : g_reg
      assign err_align_o = (size_i != MAX_SIZE) || (addr_lo_i != 2'b00);
    end else begin : g_any
      assign err_align_o = 1'b0;
    end
  endgenerate

  assign bad_o = err_opcode_o | err_size_o | err_lane_o | err_full_o |
                 err_contig_o | err_region_o | err_align_o;
endmodule

// File: rtl/screen_errslot.sv
module screen_errslot
  import screen_pkg::*;
#(
  parameter int unsigned SIZE_W = 2,
  parameter int unsigned SRC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              cap_read_i,
  input  logic [SIZE_W-1:0] cap_size_i,
  input  logic [SRC_W-1:0]  cap_source_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [2:0]        rsp_opcode_o,
  output logic [SIZE_W-1:0] rsp_size_o,
  output logic [SRC_W-1:0]  rsp_source_o
);
  logic              full_q;
  logic              read_q;
  logic [SIZE_W-1:0] size_q;
  logic [SRC_W-1:0]  source_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= 1'b0;
      read_q   <= 1'b0;
      size_q   <= '0;
      source_q <= '0;
    end else if (capture_i) begin
      full_q   <= 1'b1;
      read_q   <= cap_read_i;
      size_q   <= cap_size_i;
      source_q <= cap_source_i;
    end else if (take_i) begin
      full_q   <= 1'b0;
    end
  end

  assign full_o       = full_q;
  assign rsp_opcode_o = read_q ? RSP_ACK_DATA : RSP_ACK;
  assign rsp_size_o   = size_q;
  assign rsp_source_o = source_q;
endmodule

// File: rtl/screen_rspmux.sv
module screen_rspmux
  import screen_pkg::*;
#(
  parameter int unsigned SIZE_W = 2,
  parameter int unsigned SRC_W  = 8
) (
  input  logic                err_full_i,
  input  logic [2:0]          err_opcode_i,
  input  logic [SIZE_W-1:0]   err_size_i,
  input  logic [SRC_W-1:0]    err_source_i,
  input  logic                dev_valid_i,
  input  logic [2:0]          dev_opcode_i,
  input  logic [SIZE_W-1:0]   dev_size_i,
  input  logic [SRC_W-1:0]    dev_source_i,
  input  logic [BUS_BITS-1:0] dev_data_i,
  input  logic                dev_error_i,
  output logic                dev_ready_o,
  output logic                h_valid_o,
  input  logic                h_ready_i,
  output logic [2:0]          h_opcode_o,
  output logic [SIZE_W-1:0]   h_size_o,
  output logic [SRC_W-1:0]    h_source_o,
  output logic [BUS_BITS-1:0] h_data_o,
  output logic                h_error_o
);
  always_comb begin
    if (err_full_i) begin
      h_valid_o   = 1'b1;
      h_opcode_o  = err_opcode_i;
      h_size_o    = err_size_i;
      h_source_o  = err_source_i;
      h_data_o    = '0;
      h_error_o   = 1'b1;
      dev_ready_o = 1'b0;
    end else begin
      h_valid_o   = dev_valid_i;
      h_opcode_o  = dev_opcode_i;
      h_size_o    = dev_size_i;
      h_source_o  = dev_source_i;
      h_data_o    = dev_data_i;
      h_error_o   = dev_error_i;
      dev_ready_o = h_ready_i;
    end
  end
endmodule

// File: rtl/busreq_screen.sv
module busreq_screen
  import screen_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned SRC_W        = 8,
  parameter int unsigned SIZE_W       = 2,
  parameter bit          CONTIG_CHECK = 1'b1,
  parameter bit          REG_ONLY     = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 a_valid_i,
  output logic                 a_ready_o,
  input  logic [2:0]           a_opcode_i,
  input  logic [SIZE_W-1:0]    a_size_i,
  input  logic [ADDR_W-1:0]    a_address_i,
  input  logic [SRC_W-1:0]     a_source_i,
  input  logic [BUS_BYTES-1:0] a_mask_i,
  input  logic [BUS_BITS-1:0]  a_data_i,
  input  logic                 addr_miss_i,
  output logic                 fw_valid_o,
  input  logic                 fw_ready_i,
  output logic [2:0]           fw_opcode_o,
  output logic [SIZE_W-1:0]    fw_size_o,
  output logic [ADDR_W-1:0]    fw_address_o,
  output logic [SRC_W-1:0]     fw_source_o,
  output logic [BUS_BYTES-1:0] fw_mask_o,
  output logic [BUS_BITS-1:0]  fw_data_o,
  input  logic                 dev_d_valid_i,
  output logic                 dev_d_ready_o,
  input  logic [2:0]           dev_d_opcode_i,
  input  logic [SIZE_W-1:0]    dev_d_size_i,
  input  logic [SRC_W-1:0]     dev_d_source_i,
  input  logic [BUS_BITS-1:0]  dev_d_data_i,
  input  logic                 dev_d_error_i,
  output logic                 d_valid_o,
  input  logic                 d_ready_i,
  output logic [2:0]           d_opcode_o,
  output logic [SIZE_W-1:0]    d_size_o,
  output logic [SRC_W-1:0]     d_source_o,
  output logic [BUS_BITS-1:0]  d_data_o,
  output logic                 d_error_o
);
  // Named events for the checker.
  logic              req_bad;
  logic              gate_open;
  logic              absorb;
  logic              err_take;
  logic              err_full;
  logic              err_opcode, err_size, err_lane, err_fullw;
  logic              err_contig, err_region, err_align;
  logic [2:0]        slot_opcode;
  logic [SIZE_W-1:0] slot_size;
  logic [SRC_W-1:0]  slot_source;

  screen_rules #(
    .SIZE_W      (SIZE_W),
    .CONTIG_CHECK(CONTIG_CHECK),
    .REG_ONLY    (REG_ONLY)
  ) u_rules (
    .opcode_i    (a_opcode_i),
    .size_i      (a_size_i),
    .addr_lo_i   (a_address_i[1:0]),
    .mask_i      (a_mask_i),
    .miss_i      (addr_miss_i),
    .err_opcode_o(err_opcode),
    .err_size_o  (err_size),
    .err_lane_o  (err_lane),
    .err_full_o  (err_fullw),
    .err_contig_o(err_contig),
    .err_region_o(err_region),
    .err_align_o (err_align),
    .bad_o       (req_bad)
  );

  assign gate_open  = !err_full;
  assign absorb     = a_valid_i && gate_open && req_bad;
  assign fw_valid_o = a_valid_i && gate_open && !req_bad;
  assign a_ready_o  = gate_open && (req_bad || fw_ready_i);
  assign err_take   = err_full && d_ready_i;

  assign fw_opcode_o  = a_opcode_i;
  assign fw_size_o    = a_size_i;
  assign fw_address_o = a_address_i;
  assign fw_source_o  = a_source_i;
  assign fw_mask_o    = a_mask_i;
  assign fw_data_o    = a_data_i;

  screen_errslot #(
    .SIZE_W(SIZE_W),
    .SRC_W (SRC_W)
  ) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (absorb),
    .cap_read_i  (a_opcode_i == REQ_RD),
    .cap_size_i  (a_size_i),
    .cap_source_i(a_source_i),
    .take_i      (err_take),
    .full_o      (err_full),
    .rsp_opcode_o(slot_opcode),
    .rsp_size_o  (slot_size),
    .rsp_source_o(slot_source)
  );

  screen_rspmux #(
    .SIZE_W(SIZE_W),
    .SRC_W (SRC_W)
  ) u_mux (
    .err_full_i  (err_full),
    .err_opcode_i(slot_opcode),
    .err_size_i  (slot_size),
    .err_source_i(slot_source),
    .dev_valid_i (dev_d_valid_i),
    .dev_opcode_i(dev_d_opcode_i),
    .dev_size_i  (dev_d_size_i),
    .dev_source_i(dev_d_source_i),
    .dev_data_i  (dev_d_data_i),
    .dev_error_i (dev_d_error_i),
    .dev_ready_o (dev_d_ready_o),
    .h_valid_o   (d_valid_o),
    .h_ready_i   (d_ready_i),
    .h_opcode_o  (d_opcode_o),
    .h_size_o    (d_size_o),
    .h_source_o  (d_source_o),
    .h_data_o    (d_data_o),
    .h_error_o   (d_error_o)
  );
endmodule

// File: rtl/busreq_screen_chk.sv
module busreq_screen_chk #(
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned SIZE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_valid_i,
  input logic              a_ready_o,
  input logic              fw_valid_o,
  input logic [2:0]        fw_opcode_o,
  input logic [SIZE_W-1:0] fw_size_o,
  input logic              d_valid_o,
  input logic              d_ready_i,
  input logic              d_error_o,
  input logic [SRC_W-1:0]  d_source_o,
  input logic              dev_d_valid_i,
  input logic              dev_d_ready_o,
  input logic              err_full
);
  assert_fwd_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_valid_o |-> (fw_opcode_o == 3'b000 || fw_opcode_o == 3'b001 || fw_opcode_o == 3'b100));

  assert_fwd_size_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_valid_o |-> (fw_size_o <= SIZE_W'(2)));

  assert_absorb_fills_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_o && !fw_valid_o) |=> err_full);

  assert_slot_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_full && !d_ready_i) |=> (err_full && $stable(d_source_o)));

  assert_gate_shut_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_full |-> (!a_ready_o && !fw_valid_o));

  assert_err_priority_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_full |-> (d_valid_o && d_error_o && !dev_d_ready_o));

  assert_passthru_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_full |-> (d_valid_o == dev_d_valid_i && dev_d_ready_o == d_ready_i));
endmodule

bind busreq_screen busreq_screen_chk #(.SRC_W(SRC_W), .SIZE_W(SIZE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .a_valid_i    (a_valid_i),
  .a_ready_o    (a_ready_o),
  .fw_valid_o   (fw_valid_o),
  .fw_opcode_o  (fw_opcode_o),
  .fw_size_o    (fw_size_o),
  .d_valid_o    (d_valid_o),
  .d_ready_i    (d_ready_i),
  .d_error_o    (d_error_o),
  .d_source_o   (d_source_o),
  .dev_d_valid_i(dev_d_valid_i),
  .dev_d_ready_o(dev_d_ready_o),
  .err_full     (err_full)
);

// File: tb/sim_busreq_screen.sv
`timescale 1ns/1ps
module sim_busreq_screen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        a_valid = 0, addr_miss = 0, fw_ready = 1;
  logic [2:0]  a_op = 0;
  logic [1:0]  a_size = 0;
  logic [31:0] a_addr = 0, a_data = 0;
  logic [7:0]  a_src = 0;
  logic [3:0]  a_mask = 0;
  logic        dv_valid = 0, dv_err = 0, h_ready = 0;
  logic [2:0]  dv_op = 0;
  logic [1:0]  dv_size = 0;
  logic [7:0]  dv_src = 0;
  logic [31:0] dv_data = 0;

  logic        ar0, fv0, dr0, dvld0, derr0, ar1, fv1, dr1, dvld1, derr1;
  logic [2:0]  fop0, dop0, fop1, dop1;
  logic [1:0]  fsz0, dsz0, fsz1, dsz1;
  logic [31:0] fad0, fdt0, ddt0, fad1, fdt1, ddt1;
  logic [7:0]  fsr0, dsr0, fsr1, dsr1;
  logic [3:0]  fmk0, fmk1;

  busreq_screen u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_valid_i(a_valid), .a_ready_o(ar0),
    .a_opcode_i(a_op), .a_size_i(a_size), .a_address_i(a_addr), .a_source_i(a_src),
    .a_mask_i(a_mask), .a_data_i(a_data), .addr_miss_i(addr_miss),
    .fw_valid_o(fv0), .fw_ready_i(fw_ready), .fw_opcode_o(fop0), .fw_size_o(fsz0),
    .fw_address_o(fad0), .fw_source_o(fsr0), .fw_mask_o(fmk0), .fw_data_o(fdt0),
    .dev_d_valid_i(dv_valid), .dev_d_ready_o(dr0), .dev_d_opcode_i(dv_op),
    .dev_d_size_i(dv_size), .dev_d_source_i(dv_src), .dev_d_data_i(dv_data),
    .dev_d_error_i(dv_err), .d_valid_o(dvld0), .d_ready_i(h_ready), .d_opcode_o(dop0),
    .d_size_o(dsz0), .d_source_o(dsr0), .d_data_o(ddt0), .d_error_o(derr0));

  busreq_screen #(.CONTIG_CHECK(1'b0), .REG_ONLY(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .a_valid_i(a_valid), .a_ready_o(ar1),
    .a_opcode_i(a_op), .a_size_i(a_size), .a_address_i(a_addr), .a_source_i(a_src),
    .a_mask_i(a_mask), .a_data_i(a_data), .addr_miss_i(addr_miss),
    .fw_valid_o(fv1), .fw_ready_i(fw_ready), .fw_opcode_o(fop1), .fw_size_o(fsz1),
    .fw_address_o(fad1), .fw_source_o(fsr1), .fw_mask_o(fmk1), .fw_data_o(fdt1),
    .dev_d_valid_i(dv_valid), .dev_d_ready_o(dr1), .dev_d_opcode_i(dv_op),
    .dev_d_size_i(dv_size), .dev_d_source_i(dv_src), .dev_d_data_i(dv_data),
    .dev_d_error_i(dv_err), .d_valid_o(dvld1), .d_ready_i(h_ready), .d_opcode_o(dop1),
    .d_size_o(dsz1), .d_source_o(dsr1), .d_data_o(ddt1), .d_error_o(derr1));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {opcode, size, addr[1:0], mask, miss, bad default, bad reg-only/no-contig}
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {3'd4, 2'd2, 2'd0, 4'b1111, 1'b0, 1'b0, 1'b0},  // R8 read word
    {3'd0, 2'd2, 2'd0, 4'b1111, 1'b0, 1'b0, 1'b0},  // R8 full write
    {3'd0, 2'd2, 2'd0, 4'b0111, 1'b0, 1'b1, 1'b1},  // R4 lane missing
    {3'd1, 2'd0, 2'd2, 4'b0100, 1'b0, 1'b0, 1'b1},  // R3 byte lane 2, R7
    {3'd1, 2'd0, 2'd2, 4'b1000, 1'b0, 1'b1, 1'b1},  // R3 outside lane
    {3'd1, 2'd1, 2'd2, 4'b1100, 1'b0, 1'b0, 1'b1},  // R3 upper half
    {3'd1, 2'd1, 2'd3, 4'b1100, 1'b0, 1'b0, 1'b1},  // R3 unaligned half
    {3'd4, 2'd3, 2'd0, 4'b1111, 1'b0, 1'b1, 1'b1},  // R2 size 3
    {3'd2, 2'd2, 2'd0, 4'b1111, 1'b0, 1'b1, 1'b1},  // R1 opcode 2
    {3'd7, 2'd2, 2'd0, 4'b1111, 1'b0, 1'b1, 1'b1},  // R1 opcode 7
    {3'd1, 2'd2, 2'd0, 4'b1001, 1'b0, 1'b1, 1'b0},  // R5 gapped mask
    {3'd4, 2'd2, 2'd0, 4'b1111, 1'b1, 1'b1, 1'b1},  // R6 address miss
    {3'd1, 2'd2, 2'd0, 4'b0110, 1'b0, 1'b0, 1'b0},  // R5 run mask
    {3'd0, 2'd1, 2'd0, 4'b0011, 1'b0, 1'b0, 1'b1},  // R4 half full write
    {3'd1, 2'd0, 2'd1, 4'b0000, 1'b0, 1'b0, 1'b1},  // R3 empty mask
    {3'd4, 2'd0, 2'd0, 4'b0001, 1'b0, 1'b0, 1'b1}   // R7 byte read
  };

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: slot empty in reset and right after
    check("R12 d_valid in reset", dvld0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 d_valid after reset", dvld0, 0);
    check("R12 dev ready follows host", dr0, h_ready);
    check("R12 a_ready idle", ar0, 1);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      a_op = v[13:11]; a_size = v[10:9]; a_addr = {28'h1234567, 2'b00, v[8:7]};
      a_mask = v[6:3]; addr_miss = v[2]; a_src = 8'(i + 16);
      a_data = 32'hC0DE0000 + i; a_valid = 1'b1;
      #1;
      check($sformatf("R9/R8 fw_valid u0 vec%0d", i), fv0, !v[1]);
      check($sformatf("R9 a_ready u0 vec%0d", i), ar0, 1);
      check($sformatf("R7/R5 fw_valid u1 vec%0d", i), fv1, !v[0]);
      if (!v[1]) check($sformatf("R8 fw fields vec%0d", i),
                       {fop0, fsz0, fad0, fsr0, fmk0}, {a_op, a_size, a_addr, a_src, a_mask});
      @(negedge clk);
      a_valid = 1'b0;
      check($sformatf("R9 d_valid u0 vec%0d", i), dvld0, v[1]);
      check($sformatf("R9 d_valid u1 vec%0d", i), dvld1, v[0]);
      if (v[1]) begin
        check($sformatf("R9 err rsp vec%0d", i), {derr0, dop0, dsz0, dsr0, ddt0},
              {1'b1, (a_op == 3'd4) ? 3'd1 : 3'd0, a_size, a_src, 32'd0});
        check($sformatf("R10 stall vec%0d", i), ar0, 0);
      end
      h_ready = 1'b1;
      @(negedge clk);
      h_ready = 1'b0;
      check($sformatf("R10 slot cleared vec%0d", i), {dvld0, dvld1}, 2'b00);
    end

    // R8: device back-pressure passes to the host
    a_op = 3'd4; a_size = 2'd2; a_addr = 32'h40; a_mask = 4'hF; addr_miss = 0;
    a_src = 8'h11; fw_ready = 1'b0; a_valid = 1'b1;
    #1;
    check("R8 back-pressure a_ready", ar0, 0);
    check("R8 back-pressure fw_valid", fv0, 1);
    fw_ready = 1'b1;
    #1;
    check("R8 ready follows", ar0, 1);
    a_valid = 1'b0;

    // R11/R10: parked error competes with a device response
    @(negedge clk);
    a_op = 3'd7; a_src = 8'hA5; a_valid = 1'b1;
    @(negedge clk);
    a_op = 3'd4; a_src = 8'h22;          // legal request held back
    dv_valid = 1'b1; dv_src = 8'h3C; dv_op = 3'd1; dv_data = 32'hFEED0001;
    #1;
    check("R11 error wins source", dsr0, 8'hA5);
    check("R11 error flag", derr0, 1);
    check("R11 AccessAck for non-read", dop0, 3'd0);
    check("R11 device held", dr0, 0);
    check("R10 legal held a_ready", ar0, 0);
    check("R10 legal held fw_valid", fv0, 0);
    @(negedge clk);
    check("R9 error holds", dsr0, 8'hA5);
    h_ready = 1'b1;
    @(negedge clk);
    check("R11 device response after", {dvld0, derr0, dsr0, dop0, ddt0},
          {1'b1, 1'b0, 8'h3C, 3'd1, 32'hFEED0001});
    check("R11 device ready follows", dr0, 1);
    check("R8 held request now forwarded", {fv0, ar0, fsr0}, {1'b1, 1'b1, 8'h22});
    a_valid = 1'b0; dv_valid = 1'b0; h_ready = 1'b0;
    @(negedge clk);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule